// File: doc/BRIEF.md
# Timer Interrupt Flag Controller

This block keeps the three status flags of a timer/counter (overflow, compare A and compare B) and turns them into interrupt requests. The counter core sends it single-cycle pulses: an overflow pulse, an 8-bit match pulse for each compare channel, and a pulse for a full 16-bit match. With those pulses come two level inputs. The first selects between two independent 8-bit compares and one 16-bit compare. The second says that the compare registers are being used for input capture.

The mode inputs decide which flags can set. When the counter runs as one 16-bit unit, compare register B is the high byte, so its flag stays quiet and flag A reports the 16-bit match instead. When capture is active, register A holds captured data and its flag stays quiet. Capture in 16-bit mode also silences flag B.

Software reads the flags through a single register and clears a flag by writing a one to its bit. The interrupt vector unit clears a flag with an acknowledge pulse for that flag. Each request output is the registered AND of a global enable, the source's own enable and the source's flag.

Top module: `tmr_irq_flags`

## Requirements
- R1: An overflow pulse sets the overflow flag (bit 0) at the next clock edge, in every mode.
- R2: In dual 8-bit mode without capture, the A match pulse sets flag A (bit 1) and the B match pulse sets flag B (bit 2). The 16-bit match pulse has no effect.
- R3: In 16-bit mode, the 16-bit match pulse sets flag A. The A match pulse and the B match pulse do not set any flag, and flag B never sets.
- R4: In capture mode, flag A never sets. In capture mode combined with 16-bit mode, flag B also never sets. In capture mode combined with dual mode, the B match pulse still sets flag B.
- R5: A write with a one in a flag's bit clears that flag. A zero in that bit leaves the flag unchanged.
- R6: An acknowledge pulse on a flag's line clears that flag at the next edge.
- R7: When a set event and a clear (write-one or acknowledge) reach the same flag in one cycle, the flag ends up set.
- R8: Request i is high in the cycle after the global enable, enable i and flag i are all high in the same cycle, and is low otherwise.
- R9: The read data carries the flags in bits 0 to 2 and zero in every higher bit. After reset, all flags and requests are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_mode | input | 1 | 1: single 16-bit compare, 0: two 8-bit compares |
| capture_mode | input | 1 | Compare registers in use for input capture |
| ovf_pulse | input | 1 | Counter overflow event |
| hit_a | input | 1 | 8-bit match on channel A |
| hit_b | input | 1 | 8-bit match on channel B |
| hit_wide | input | 1 | 16-bit match against {B, A} |
| ack | input | 3 | Per-flag acknowledge from the vector unit |
| glob_ie | input | 1 | Global interrupt enable |
| src_ie | input | 3 | Per-source interrupt enables |
| bus_wr | input | 1 | Write strobe to the flag register |
| bus_wdata | input | DATA_W | Write data, a one clears the matching flag |
| bus_rdata | output | DATA_W | Flag register read value |
| irq | output | 3 | Registered interrupt requests |

## Verification
The bench uses the default 8-bit data width. With that width, five padding bits above the flags get random write data and must still read as zero. A behavioural model runs next to the design and is compared with it on every cycle. Each mode combination gets its own long random phase, so every pairing of a set pulse with write-one clears and acknowledges occurs many times. Directed steps pin down the collision and enable-latency cases with literal expected values.

// File: rtl/tifc_pkg.sv
package tifc_pkg;
  localparam int NUM_SRC  = 3;
  localparam int FLG_OVF  = 0;
  localparam int FLG_CMPA = 1;
  localparam int FLG_CMPB = 2;

  typedef enum logic [1:0] {
    MODE_DUAL8   = 2'b00,
    MODE_WIDE16  = 2'b01,
    MODE_CAP8    = 2'b10,
    MODE_CAP16   = 2'b11
  } tifc_mode_e;

  // next value of one flag: a set beats any clear
  function automatic logic flag_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  // which compare sources may raise a flag in the given mode
  function automatic logic [NUM_SRC-1:0] route_sets(
    input tifc_mode_e mode, input logic ovf, input logic ha,
    input logic hb, input logic hw);
    logic [NUM_SRC-1:0] s;
    s           = '0;
    s[FLG_OVF]  = ovf;
    unique case (mode)
      MODE_DUAL8:  begin s[FLG_CMPA] = ha; s[FLG_CMPB] = hb; end
      MODE_WIDE16: begin s[FLG_CMPA] = hw; end
      MODE_CAP8:   begin s[FLG_CMPB] = hb; end
      default:     ;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/tifc_event_route.sv
module tifc_event_route
  import tifc_pkg::*;
(
  input  logic               wide_mode,
  input  logic               capture_mode,
  input  logic               ovf_pulse,
  input  logic               hit_a,
  input  logic               hit_b,
  input  logic               hit_wide,
  output tifc_mode_e         mode_o,
  output logic [NUM_SRC-1:0] set_o
);
  always_comb begin
    mode_o = tifc_mode_e'({capture_mode, wide_mode});
    set_o  = route_sets(mode_o, ovf_pulse, hit_a, hit_b, hit_wide);
  end
endmodule

// File: rtl/tifc_flag_bit.sv
module tifc_flag_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  import tifc_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_o <= 1'b0;
    else        flag_o <= flag_next(flag_o, set_i, clr_i);
  end

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o);
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !set_i) |=> (flag_o == $past(flag_o)));
endmodule

// File: rtl/tifc_irq_gate.sv
module tifc_irq_gate
  import tifc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               glob_ie,
  input  logic [NUM_SRC-1:0] src_ie,
  input  logic [NUM_SRC-1:0] flags,
  output logic [NUM_SRC-1:0] irq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= '0;
    else        irq_o <= flags & src_ie & {NUM_SRC{glob_ie}};
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
    assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[i] |-> $past(glob_ie && src_ie[i] && flags[i]));
    assert_irq_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (glob_ie && src_ie[i] && flags[i]) |=> irq_o[i]);
  end
endmodule

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags
  import tifc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide_mode,
  input  logic              capture_mode,
  input  logic              ovf_pulse,
  input  logic              hit_a,
  input  logic              hit_b,
  input  logic              hit_wide,
  input  logic [2:0]        ack,
  input  logic              glob_ie,
  input  logic [2:0]        src_ie,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [2:0]        irq
);
  localparam int PAD_W = DATA_W - NUM_SRC;

  tifc_mode_e         mode_w;
  logic [NUM_SRC-1:0] set_w;
  logic [NUM_SRC-1:0] clr_w;
  logic [NUM_SRC-1:0] flags_w;

  tifc_event_route u_route (
    .wide_mode    (wide_mode),
    .capture_mode (capture_mode),
    .ovf_pulse    (ovf_pulse),
    .hit_a        (hit_a),
    .hit_b        (hit_b),
    .hit_wide     (hit_wide),
    .mode_o       (mode_w),
    .set_o        (set_w)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    assign clr_w[i] = ack[i] | (bus_wr & bus_wdata[i]);
    tifc_flag_bit u_bit (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_w[i]),
      .clr_i  (clr_w[i]),
      .flag_o (flags_w[i])
    );
  end

  if (PAD_W > 0) begin : g_pad
    assign bus_rdata = {{PAD_W{1'b0}}, flags_w};
  end else begin : g_nopad
    assign bus_rdata = flags_w[DATA_W-1:0];
  end

  tifc_irq_gate u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .glob_ie (glob_ie),
    .src_ie  (src_ie),
    .flags   (flags_w),
    .irq_o   (irq)
  );

  assert_ovf_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |=> bus_rdata[FLG_OVF]);
  assert_b_quiet_wide_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_w[FLG_CMPB]) |-> $past(!wide_mode && hit_b));
  assert_a_quiet_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_w[FLG_CMPA]) |-> $past(!capture_mode));
  assert_a_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_w[FLG_CMPA]) |-> $past(wide_mode ? hit_wide : hit_a));
  assert_rdata_pad_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata >> NUM_SRC) == '0);
endmodule

// File: tb/tmr_irq_flags_tb.sv
`timescale 1ns/1ps
module tmr_irq_flags_tb;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wide_mode = 0, capture_mode = 0, ovf_pulse = 0, hit_a = 0, hit_b = 0, hit_wide = 0;
  logic [2:0] ack = '0, src_ie = '0;
  logic glob_ie = 0, bus_wr = 0;
  logic [DW-1:0] bus_wdata = '0, bus_rdata;
  logic [2:0] irq;

  int total = 0, bad = 0;
  bit done = 0;
  logic [2:0] m_flag = '0, m_irq = '0;

  always #4 clk = ~clk;

  tmr_irq_flags #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .capture_mode(capture_mode),
    .ovf_pulse(ovf_pulse), .hit_a(hit_a), .hit_b(hit_b), .hit_wide(hit_wide),
    .ack(ack), .glob_ie(glob_ie), .src_ie(src_ie), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h t=%0t", tag, got, exp, $time);
    end
  endtask

  // behavioural model of one clock edge, then compare with the design
  task automatic step();
    logic [2:0] nf;
    @(negedge clk);
    m_irq = glob_ie ? (src_ie & m_flag) : 3'b000;
    for (int b = 0; b < 3; b++) begin
      bit s, c;
      s = 0;
      if (b == 0) s = ovf_pulse;
      if (b == 1 && !capture_mode) s = wide_mode ? hit_wide : hit_a;
      if (b == 2 && !wide_mode) s = hit_b;
      c = ack[b] || (bus_wr && bus_wdata[b]);
      if (s) nf[b] = 1'b1;
      else if (c) nf[b] = 1'b0;
      else nf[b] = m_flag[b];
    end
    m_flag = nf;
    chk("R1 ovf flag", bus_rdata[0], m_flag[0]);
    chk(capture_mode ? "R4 flag A" : (wide_mode ? "R3 flag A" : "R2 flag A"),
        bus_rdata[1], m_flag[1]);
    chk(wide_mode ? "R3 flag B" : (capture_mode ? "R4 flag B" : "R2 flag B"),
        bus_rdata[2], m_flag[2]);
    chk("R9 pad bits", 32'(bus_rdata >> 3), 0);
    chk("R8 irq", irq, m_irq);
  endtask

  task automatic idle();
    ovf_pulse = 0; hit_a = 0; hit_b = 0; hit_wide = 0; ack = '0;
    bus_wr = 0; bus_wdata = '0;
  endtask

  initial begin
    #100000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset flags", bus_rdata, 0);
    chk("R9 reset irq", irq, 0);
    rst_n = 1;
    step();

    // R2: A match in dual mode
    hit_a = 1; step(); idle();
    chk("R2 A set", bus_rdata, 8'h02);
    // R5: writing zeros leaves flags
    bus_wr = 1; bus_wdata = 8'h00; ovf_pulse = 1; step(); idle();
    chk("R5 zero write", bus_rdata, 8'h03);
    // R7: write-one clear collides with set
    bus_wr = 1; bus_wdata = 8'h02; hit_a = 1; step(); idle();
    chk("R7 set beats write", bus_rdata, 8'h03);
    bus_wr = 1; bus_wdata = 8'h02; step(); idle();
    chk("R5 write one", bus_rdata, 8'h01);
    // R7 with acknowledge, then R6
    ack = 3'b001; ovf_pulse = 1; step(); idle();
    chk("R7 set beats ack", bus_rdata, 8'h01);
    ack = 3'b001; step(); idle();
    chk("R6 ack clear", bus_rdata, 8'h00);
    // R8 latency
    glob_ie = 1; src_ie = 3'b111; hit_b = 1; step(); idle();
    chk("R8 irq lags flag", irq, 3'b000);
    step();
    chk("R8 irq follows", irq, 3'b100);
    glob_ie = 0; step(); step();
    chk("R8 global gate", irq, 3'b000);
    // R3: wide mode
    bus_wr = 1; bus_wdata = 8'hFF; step(); idle();
    chk("R9 pad after FF write", bus_rdata, 8'h00);
    wide_mode = 1; hit_a = 1; hit_b = 1; step(); idle();
    chk("R3 8-bit hits ignored", bus_rdata, 8'h00);
    hit_wide = 1; step(); idle();
    chk("R3 wide hit sets A", bus_rdata, 8'h02);
    // R4: capture
    bus_wr = 1; bus_wdata = 8'h07; step(); idle();
    capture_mode = 1; hit_wide = 1; hit_b = 1; step(); idle();
    chk("R4 cap16 quiet", bus_rdata, 8'h00);
    wide_mode = 0; hit_a = 1; hit_b = 1; step(); idle();
    chk("R4 cap8 B only", bus_rdata, 8'h04);

    // random phases, one per mode
    for (int m = 0; m < 4; m++) begin
      wide_mode = m[0]; capture_mode = m[1];
      for (int n = 0; n < 600; n++) begin
        ovf_pulse = ($urandom % 4) == 0;
        hit_a     = ($urandom % 3) == 0;
        hit_b     = ($urandom % 3) == 0;
        hit_wide  = ($urandom % 3) == 0;
        ack       = (($urandom % 4) == 0) ? 3'($urandom) : 3'b000;
        bus_wr    = ($urandom % 4) == 0;
        bus_wdata = DW'($urandom);
        if (($urandom % 8) == 0) glob_ie = ~glob_ie;
        if (($urandom % 8) == 0) src_ie = 3'($urandom);
        step();
      end
      idle();
      step();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule